// File: doc/BRIEF.md
# Four-Level Serial Port Interrupt Prioritizer

This block merges the four interrupt causes of an asynchronous serial port into one identification byte and one interrupt line. The four causes are receive line errors, received data ready, transmit holding register empty and modem line changes. Each cause keeps its own pending flag. A flag is set by its event and cleared by the register access that services that cause. When several enabled flags are pending, a fixed priority picks the one that the identification byte reports.

Events reach the block as single-cycle pulses, except for the transmit holding empty flag, which is a level. Software accesses reach the block as single-cycle strobes. The surrounding register file supplies a 4-bit enable field and an auxiliary gate bit. The gate bit decides whether the merged request is driven onto the system interrupt line. The status registers themselves live outside the block.

Top module: `uart_irq_prioritizer`

## Requirements
- R1: After reset, no cause is pending, `iid_o` reads 8'h01 and `irq_o` is 0.
- R2: When several enabled causes are pending, `iid_o` reports the highest one. The order from highest to lowest is line error, received data, holding empty, modem change.
- R3: `iid_o[0]` is 1 when no enabled cause is pending and 0 otherwise. While a cause is reported, `iid_o[2:1]` is 2'b11 for line error, 2'b10 for received data, 2'b01 for holding empty and 2'b00 for modem change. `iid_o[7:3]` is always 0. The possible values are therefore 8'h01, 8'h06, 8'h04, 8'h02 and 8'h00.
- R4: `ier_i[0]` enables received data, `ier_i[1]` holding empty, `ier_i[2]` line error and `ier_i[3]` modem change. A disabled cause is neither reported nor requested. Its pending flag is kept, so the cause appears as soon as it is enabled.
- R5: `irq_o` is 1 only when `out2_i` is 1 and at least one enabled cause is pending. The identification byte does not depend on `out2_i`.
- R6: A pulse on any bit of `line_err_i` makes line error pending (bit 0 overrun, bit 1 parity, bit 2 framing, bit 3 break). A line status read clears it. An identification read does not.
- R7: A pulse on `rx_avail_i` makes received data pending. A receive buffer read clears it.
- R8: A pulse on any bit of `modem_delta_i` makes modem change pending. A modem status read clears it.
- R9: A transmit holding register write clears a pending holding empty cause.
- R10: An identification read clears holding empty only if that read returned 8'h02. A read that returns any other code leaves holding empty pending.
- R11: Holding empty becomes pending on a 0-to-1 transition of `thr_empty_i`. While `thr_empty_i` stays at 1 after a clear, the cause is not raised again.
- R12: If a cause's event and its clearing access come in the same cycle, the cause ends up pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_err_i | input | 4 | Receive error event pulses: overrun, parity, framing, break |
| rx_avail_i | input | 1 | Pulse: a character was moved into the receive buffer |
| thr_empty_i | input | 1 | Level: transmit holding register is empty |
| modem_delta_i | input | 4 | Modem input change event pulses |
| ier_i | input | 4 | Per-cause enable bits |
| out2_i | input | 1 | Auxiliary gate for the interrupt line |
| iid_rd_i | input | 1 | Strobe: identification register read |
| lsr_rd_i | input | 1 | Strobe: line status register read |
| rbr_rd_i | input | 1 | Strobe: receive buffer read |
| msr_rd_i | input | 1 | Strobe: modem status register read |
| thr_wr_i | input | 1 | Strobe: transmit holding register write |
| iid_o | output | 8 | Identification byte |
| irq_o | output | 1 | Gated interrupt request |

## Verification
The embedded assertions check several rules on every cycle:
- the upper identification bits stay zero;
- the gate bit suppresses the request line;
- a raised request always comes with a pending code;
- an enabled line error always wins;
- an event always leaves its flag set one cycle later, and a lone clearing access always leaves it cleared;
- a holding-empty rising edge or write always has its effect.

Some behaviour can only be shown by the bench's ordered scenarios, because it depends on the history of accesses:
- the full priority ladder as causes are serviced one by one;
- an identification read that must not clear holding empty because it returned a different code;
- a flag that stays remembered while its cause is disabled;
- no re-arm while the empty flag stays high.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int IID_W   = 8;
    localparam int ERR_W   = 4;
    localparam int MDM_W   = 4;
    localparam int EN_W    = 4;
    localparam int CODE_W  = 2;
    localparam int PAD_W   = IID_W - CODE_W - 1;

    typedef enum logic [CODE_W-1:0] {
        SRC_MODEM  = 2'b00,
        SRC_THRE   = 2'b01,
        SRC_RXDATA = 2'b10,
        SRC_LINE   = 2'b11
    } irq_src_e;

    typedef struct packed {
        logic line;
        logic rxd;
        logic thre;
        logic modem;
    } pend_t;

    // enable field layout: 0 rx data, 1 holding empty, 2 line error, 3 modem
    function automatic pend_t en_to_mask(input logic [EN_W-1:0] en);
        pend_t m;
        m.rxd   = en[0];
        m.thre  = en[1];
        m.line  = en[2];
        m.modem = en[3];
        return m;
    endfunction

endpackage

// File: rtl/irq_event_flag.sv
module irq_event_flag #(
    parameter int EVW = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [EVW-1:0] set_i,
    input  logic           clr_i,
    output logic           pend_o
);

    typedef struct packed {
        logic pend;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (|set_i) begin
            st_d.pend = 1'b1;
        end else if (clr_i) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;

    // R12 / R6 / R7 / R8: an event always leaves the flag set
    a_r12_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> pend_o);

    // R6 / R7 / R8: a lone clearing access leaves the flag cleared
    a_r6_lone_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(|set_i)) |=> !pend_o);

endmodule

// File: rtl/thre_arm.sv
module thre_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic empty_i,
    input  logic thr_wr_i,
    input  logic iid_rd_i,
    input  logic shows_thre_i,
    output logic pend_o
);

    typedef struct packed {
        logic prev;
        logic pend;
    } arm_st_t;

    arm_st_t st_d, st_q;
    logic    rise;

    assign rise = empty_i && !st_q.prev;

    always_comb begin
        st_d      = st_q;
        st_d.prev = empty_i;
        if (rise) begin
            st_d.pend = 1'b1;
        end else if (thr_wr_i || (iid_rd_i && shows_thre_i)) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.prev <= 1'b1;
            st_q.pend <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;

    a_r11_rise_arms: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> pend_o);

    a_r9_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr_i && !rise) |=> !pend_o);

    a_r10_other_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && iid_rd_i && !shows_thre_i && !thr_wr_i) |=> pend_o);

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import uart_irq_pkg::*;
(
    input  pend_t             pend_i,
    input  logic [EN_W-1:0]   ier_i,
    input  logic              out2_i,
    output logic [IID_W-1:0]  iid_o,
    output logic              irq_o,
    output logic              shows_thre_o
);

    pend_t    act;
    irq_src_e code;
    logic     any;

    always_comb begin
        act  = pend_i & en_to_mask(ier_i);
        any  = |act;
        code = SRC_MODEM;
        if (act.line) begin
            code = SRC_LINE;
        end else if (act.rxd) begin
            code = SRC_RXDATA;
        end else if (act.thre) begin
            code = SRC_THRE;
        end
    end

    assign iid_o        = {{PAD_W{1'b0}}, code, ~any};
    assign irq_o        = any && out2_i;
    assign shows_thre_o = any && (code == SRC_THRE);

endmodule

// File: rtl/uart_irq_prioritizer.sv
module uart_irq_prioritizer
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ERR_W-1:0]  line_err_i,
    input  logic              rx_avail_i,
    input  logic              thr_empty_i,
    input  logic [MDM_W-1:0]  modem_delta_i,
    input  logic [EN_W-1:0]   ier_i,
    input  logic              out2_i,
    input  logic              iid_rd_i,
    input  logic              lsr_rd_i,
    input  logic              rbr_rd_i,
    input  logic              msr_rd_i,
    input  logic              thr_wr_i,
    output logic [IID_W-1:0]  iid_o,
    output logic              irq_o
);

    pend_t pend;
    logic  shows_thre;

    irq_event_flag #(.EVW(ERR_W)) u_line (
        .clk(clk), .rst_n(rst_n), .set_i(line_err_i),
        .clr_i(lsr_rd_i), .pend_o(pend.line)
    );

    irq_event_flag #(.EVW(1)) u_rxd (
        .clk(clk), .rst_n(rst_n), .set_i(rx_avail_i),
        .clr_i(rbr_rd_i), .pend_o(pend.rxd)
    );

    irq_event_flag #(.EVW(MDM_W)) u_modem (
        .clk(clk), .rst_n(rst_n), .set_i(modem_delta_i),
        .clr_i(msr_rd_i), .pend_o(pend.modem)
    );

    thre_arm u_thre (
        .clk(clk), .rst_n(rst_n), .empty_i(thr_empty_i),
        .thr_wr_i(thr_wr_i), .iid_rd_i(iid_rd_i),
        .shows_thre_i(shows_thre), .pend_o(pend.thre)
    );

    irq_prio_enc u_enc (
        .pend_i(pend), .ier_i(ier_i), .out2_i(out2_i),
        .iid_o(iid_o), .irq_o(irq_o), .shows_thre_o(shows_thre)
    );

    a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        iid_o[IID_W-1:CODE_W+1] == '0);

    a_r5_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !out2_i |-> !irq_o);

    a_r3_irq_has_code: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !iid_o[0]);

    a_r2_line_first: assert property (@(posedge clk) disable iff (!rst_n)
        (pend.line && ier_i[2]) |-> (iid_o[2:0] == 3'b110));

endmodule

// File: tb/sim_uart_irq_prioritizer.sv
module sim_uart_irq_prioritizer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] line_err = '0;
    logic       rx_avail = 1'b0;
    logic       thr_empty = 1'b1;
    logic [3:0] modem_delta = '0;
    logic [3:0] ier = '0;
    logic       out2 = 1'b0;
    logic       iid_rd = 1'b0, lsr_rd = 1'b0, rbr_rd = 1'b0, msr_rd = 1'b0, thr_wr = 1'b0;
    logic [7:0] iid;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] iid;
        logic       irq;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    uart_irq_prioritizer u0 (
        .clk(clk), .rst_n(rst_n), .line_err_i(line_err), .rx_avail_i(rx_avail),
        .thr_empty_i(thr_empty), .modem_delta_i(modem_delta), .ier_i(ier),
        .out2_i(out2), .iid_rd_i(iid_rd), .lsr_rd_i(lsr_rd), .rbr_rd_i(rbr_rd),
        .msr_rd_i(msr_rd), .thr_wr_i(thr_wr), .iid_o(iid), .irq_o(irq)
    );

    // monitor: compare outputs a little after each edge
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (iid !== e.iid || irq !== e.irq) begin
                errors++;
                $display("FAIL %s: iid=%02h irq=%0b expected iid=%02h irq=%0b",
                         e.tag, iid, irq, e.iid, e.irq);
            end
        end
    end

    // driver: inputs already set at a falling edge; push expectation, run one cycle
    task automatic cyc(input logic [7:0] e_iid, input logic e_irq, input string tag);
        exp_t e;
        e.iid = e_iid; e.irq = e_irq; e.tag = tag;
        sb.push_back(e);
        @(posedge clk);
        @(negedge clk);
        line_err = '0; rx_avail = 1'b0; modem_delta = '0;
        iid_rd = 1'b0; lsr_rd = 1'b0; rbr_rd = 1'b0; msr_rd = 1'b0; thr_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(8'h01, 1'b0, "R1 reset idle");
        ier = 4'hF; out2 = 1'b1;
        cyc(8'h01, 1'b0, "R1 enabled but idle");

        rx_avail = 1'b1;        cyc(8'h04, 1'b1, "R7 rx data raised");
        line_err = 4'b0100;     cyc(8'h06, 1'b1, "R2 line over rx");
        modem_delta = 4'b0001;  cyc(8'h06, 1'b1, "R2 line over modem");
        iid_rd = 1'b1;          cyc(8'h06, 1'b1, "R6 id read keeps line");
        lsr_rd = 1'b1;          cyc(8'h04, 1'b1, "R6 lsr read clears line");
        rbr_rd = 1'b1;          cyc(8'h00, 1'b1, "R7 rbr read clears rx, R3 modem code");
        thr_empty = 1'b0;       cyc(8'h00, 1'b1, "R11 empty low");
        thr_empty = 1'b1;       cyc(8'h02, 1'b1, "R11 rise arms, R2 thre over modem");
        iid_rd = 1'b1;          cyc(8'h00, 1'b1, "R10 id read clears thre");
        cyc(8'h00, 1'b1, "R11 no re-arm while high");
        cyc(8'h00, 1'b1, "R11 no re-arm while high 2");
        msr_rd = 1'b1;          cyc(8'h01, 1'b0, "R8 msr read clears modem");

        out2 = 1'b0; rx_avail = 1'b1; cyc(8'h04, 1'b0, "R5 gate low hides irq");
        out2 = 1'b1;            cyc(8'h04, 1'b1, "R5 gate high shows irq");
        ier = 4'h0;             cyc(8'h01, 1'b0, "R4 all disabled");
        ier = 4'h1;             cyc(8'h04, 1'b1, "R4 pending kept, rx re-enabled");
        rbr_rd = 1'b1;          cyc(8'h01, 1'b0, "R7 rbr read clears");

        ier = 4'hF;
        thr_empty = 1'b0;       cyc(8'h01, 1'b0, "R11 empty low again");
        thr_empty = 1'b1;       cyc(8'h02, 1'b1, "R11 rise arms again");
        thr_wr = 1'b1;          cyc(8'h01, 1'b0, "R9 write clears thre");

        thr_empty = 1'b0;       cyc(8'h01, 1'b0, "R10 setup empty low");
        thr_empty = 1'b1;       cyc(8'h02, 1'b1, "R10 setup thre");
        rx_avail = 1'b1;        cyc(8'h04, 1'b1, "R2 rx over thre");
        iid_rd = 1'b1;          cyc(8'h04, 1'b1, "R10 id read returns rx");
        rbr_rd = 1'b1;          cyc(8'h02, 1'b1, "R10 thre still pending");

        line_err = 4'b0001; lsr_rd = 1'b1; cyc(8'h06, 1'b1, "R12 overrun with lsr read");
        lsr_rd = 1'b1;          cyc(8'h02, 1'b1, "R6 lsr read clears overrun");
        line_err = 4'b1000;     cyc(8'h06, 1'b1, "R6 break raises");
        lsr_rd = 1'b1;          cyc(8'h02, 1'b1, "R6 clear after break");
        line_err = 4'b0010;     cyc(8'h06, 1'b1, "R6 parity raises");
        lsr_rd = 1'b1;          cyc(8'h02, 1'b1, "R6 clear after parity");
        thr_wr = 1'b1;          cyc(8'h01, 1'b0, "R9 write clears thre");

        ier = 4'h8;
        thr_empty = 1'b0;       cyc(8'h01, 1'b0, "R4 thre masked, low");
        thr_empty = 1'b1;       cyc(8'h01, 1'b0, "R4 thre masked, risen");
        modem_delta = 4'b1000;  cyc(8'h00, 1'b1, "R8 modem only enabled");
        ier = 4'hA;             cyc(8'h02, 1'b1, "R4 thre kept while masked");
        msr_rd = 1'b1; thr_wr = 1'b1; cyc(8'h01, 1'b0, "R8 R9 both cleared");

        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
        end
        #5;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule